// File: doc/BRIEF.md
# Extended Register Indirect Access Unit

This block is the register-file side of an Ethernet PHY management function. Software sees only two directly addressed 16-bit registers, a control word and a data window, on a simple read/write port that takes the place of the serial management framing. Through these two registers it reaches an extended register space. The control word chooses one of four access functions and names a target device. The data window then either loads the internal extended-address pointer or reads and writes the register that the pointer selects. Two of the data functions advance the pointer by themselves, so software can walk a block of registers without reloading the address each time.

One extended device is built in. It is a bank of ten 8-bit LED configuration words with fixed power-on contents. Every stored word is driven onto a flat output bus, and a one-hot strobe marks the word that a write is updating, so neighbouring LED logic can take in new settings. Any other device, and any extended address outside the bank, reads as zero and is not written.

Top module: `mmd_indirect_unit`

## Requirements
- R1: After reset the bank holds, at extended addresses 0x1E0 up to 0x1E9, the values 0xC5, 0x67, 0x70, 0x03, 0x20, 0x00, 0x40, 0x00, 0x40, 0x20. The LED word bus shows the same values, with word i in bits 8*i+7:8*i.
- R2: The control register is at direct address 0x0D. Bits 15:14 hold the function code: 00 address, 01 data, 10 data with advance on every access, 11 data with advance on writes only. Bits 4:0 hold the device number. Bits 13:5 are dropped on write and read back as zero.
- R3: The data register is at direct address 0x0E. With function 00, a write to it loads the 16-bit pointer and a read of it returns the pointer.
- R4: With function 01, data reads and writes reach the addressed register, and the pointer does not change.
- R5: With function 10, the pointer rises by one after each data read and after each data write.
- R6: With function 11, the pointer rises by one after each data write. Data reads leave it unchanged.
- R7: Only bits 7:0 of a written value are stored. Bank reads return bits 15:8 as zero.
- R8: When the device is not 0x1F, or the pointer lies outside 0x1E0 to 0x1E9, data reads return 0x0000 and writes change nothing. The pointer still advances as the function code says.
- R9: A read of any direct address other than 0x0D or 0x0E returns 0x0000.
- R10: A write that stores into the bank raises exactly one strobe bit, the bit for that word, in the same cycle. After the clock edge the new value appears on the LED word bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Direct register write request |
| reg_rd | input | 1 | Direct register read request. Any side effect takes place at the clock edge |
| reg_addr | input | 5 | Direct register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from the current address and state |
| led_wr_stb | output | 10 | One-hot strobe for the bank word being written |
| led_words | output | 80 | All bank words, word i in bits 8*i+7:8*i |

## Verification
The bench uses the default parameters: a ten-word bank at base 0x1E0, device number 0x1F, and a 5-bit device field. With these values an auto-advancing read walk passes beyond the last word into unimplemented space, and the advanced pointer can be read back in address mode. The all-ones control write shows the dropped middle bits. Accesses to a neighbouring device number are shown to leave the bank untouched.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

  typedef enum logic [1:0] {
    FN_ADDR   = 2'b00,
    FN_DATA   = 2'b01,
    FN_INC_RW = 2'b10,
    FN_INC_WR = 2'b11
  } mmd_fn_e;

  // Power-on contents of the LED configuration words, by word index.
  function automatic logic [7:0] led_reset_word(input int idx);
    case (idx)
      0:       led_reset_word = 8'hC5;
      1:       led_reset_word = 8'h67;
      2:       led_reset_word = 8'h70;
      3:       led_reset_word = 8'h03;
      4:       led_reset_word = 8'h20;
      5:       led_reset_word = 8'h00;
      6:       led_reset_word = 8'h40;
      7:       led_reset_word = 8'h00;
      8:       led_reset_word = 8'h40;
      9:       led_reset_word = 8'h20;
      default: led_reset_word = 8'h00;
    endcase
  endfunction

  // Whether a data-window access moves the pointer under a given function.
  function automatic logic ptr_advances(input mmd_fn_e fn, input logic is_wr);
    case (fn)
      FN_INC_RW: ptr_advances = 1'b1;
      FN_INC_WR: ptr_advances = is_wr;
      default:   ptr_advances = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mmd_ctrl_reg.sv
module mmd_ctrl_reg
  import mmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEV_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              data_we,
  input  logic              data_re,
  input  logic [DATA_W-1:0] wdata,
  output mmd_fn_e           fn,
  output logic [DEV_W-1:0]  dev,
  output logic [DATA_W-1:0] ptr,
  output logic              ptr_adv,
  output logic              ptr_load
);

  assign ptr_load = data_we && (fn == FN_ADDR);
  assign ptr_adv  = (data_we || data_re) && ptr_advances(fn, data_we);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fn  <= FN_ADDR;
      dev <= '0;
      ptr <= '0;
    end else begin
      if (ctrl_we) begin
        fn  <= mmd_fn_e'(wdata[DATA_W-1 -: 2]);
        dev <= wdata[DEV_W-1:0];
      end
      if (ptr_load)     ptr <= wdata;
      else if (ptr_adv) ptr <= ptr + 1'b1;
    end
  end

  // R3: an address-mode data write loads the pointer
  a_r3_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && fn == FN_ADDR) |=> ptr == $past(wdata));
  // R4: plain data mode never moves the pointer
  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_we || data_re) && fn == FN_DATA) |=> $stable(ptr));
  // R5: advance on every data access
  a_r5_ptr_inc: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_we || data_re) && fn == FN_INC_RW) |=> ptr == $past(ptr) + 1'b1);
  // R6: reads do not advance in write-advance mode
  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (data_re && !data_we && fn == FN_INC_WR) |=> $stable(ptr));

endmodule

// File: rtl/mmd_led_bank.sv
module mmd_led_bank
  import mmd_pkg::*;
#(
  parameter int COUNT  = 10,
  parameter int WORD_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [WORD_W-1:0]       wdata,
  output logic [WORD_W-1:0]       rd_word,
  output logic [COUNT-1:0]        wr_stb,
  output logic [COUNT*WORD_W-1:0] words
);

  logic [WORD_W-1:0] mem [COUNT];

  for (genvar i = 0; i < COUNT; i++) begin : g_word
    assign wr_stb[i] = we && (idx == IDX_W'(i));
    assign words[i*WORD_W +: WORD_W] = mem[i];
    always_ff @(posedge clk) begin
      if (!rst_n)         mem[i] <= WORD_W'(led_reset_word(i));
      else if (wr_stb[i]) mem[i] <= wdata;
    end
  end

  assign rd_word = (32'(idx) < COUNT) ? mem[idx] : '0;

  // R10: at most one word strobed per cycle
  a_r10_stb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));
  // R10: a strobed word takes the written value
  a_r10_stb_store: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rd_word == $past(wdata) || idx != $past(idx));

endmodule

// File: rtl/mmd_indirect_unit.sv
module mmd_indirect_unit
  import mmd_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          DEV_W     = 5,
  parameter int          LED_COUNT = 10,
  parameter int          LED_W     = 8,
  parameter logic [4:0]  CTRL_ADDR = 5'h0D,
  parameter logic [4:0]  DATA_ADDR = 5'h0E,
  parameter logic [4:0]  DEV_ID    = 5'h1F,
  parameter logic [15:0] LED_BASE  = 16'h01E0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [4:0]                 reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  output logic [LED_COUNT-1:0]       led_wr_stb,
  output logic [LED_COUNT*LED_W-1:0] led_words
);

  localparam int          IDX_W   = (LED_COUNT > 1) ? $clog2(LED_COUNT) : 1;
  localparam int          PAD_W   = DATA_W - 2 - DEV_W;
  localparam logic [DATA_W:0] LED_END = {1'b0, LED_BASE} + (DATA_W+1)'(LED_COUNT);

  mmd_fn_e             fn;
  logic [DEV_W-1:0]    dev;
  logic [DATA_W-1:0]   ptr;
  logic                ptr_adv, ptr_load;
  logic                ctrl_sel, data_sel;
  logic                ctrl_we, data_we, data_re;
  logic                dev_hit, in_bank, bank_we;
  logic [DATA_W-1:0]   ptr_off;
  logic [IDX_W-1:0]    bank_idx;
  logic [LED_W-1:0]    bank_rd;

  assign ctrl_sel = (reg_addr == CTRL_ADDR);
  assign data_sel = (reg_addr == DATA_ADDR);
  assign ctrl_we  = reg_wr && ctrl_sel;
  assign data_we  = reg_wr && data_sel;
  assign data_re  = reg_rd && data_sel && !reg_wr;

  assign dev_hit  = (dev == DEV_ID[DEV_W-1:0]);
  assign in_bank  = dev_hit && (ptr >= LED_BASE) && ({1'b0, ptr} < LED_END);
  assign ptr_off  = ptr - LED_BASE;
  assign bank_idx = ptr_off[IDX_W-1:0];
  assign bank_we  = data_we && (fn != FN_ADDR) && in_bank;

  mmd_ctrl_reg #(.DATA_W(DATA_W), .DEV_W(DEV_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_we  (ctrl_we),
    .data_we  (data_we),
    .data_re  (data_re),
    .wdata    (reg_wdata),
    .fn       (fn),
    .dev      (dev),
    .ptr      (ptr),
    .ptr_adv  (ptr_adv),
    .ptr_load (ptr_load)
  );

  mmd_led_bank #(.COUNT(LED_COUNT), .WORD_W(LED_W), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bank_we),
    .idx     (bank_idx),
    .wdata   (reg_wdata[LED_W-1:0]),
    .rd_word (bank_rd),
    .wr_stb  (led_wr_stb),
    .words   (led_words)
  );

  always_comb begin
    reg_rdata = '0;
    if (ctrl_sel)
      reg_rdata = {fn, {PAD_W{1'b0}}, dev};
    else if (data_sel) begin
      if (fn == FN_ADDR)  reg_rdata = ptr;
      else if (in_bank)   reg_rdata = DATA_W'(bank_rd);
    end
  end

  // R8: a foreign device never strobes the bank
  a_r8_foreign_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !dev_hit) |-> led_wr_stb == '0);
  // R2: the control read-back keeps the middle bits clear
  a_r2_ctrl_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && ctrl_sel) |-> reg_rdata[DATA_W-3:DEV_W] == '0);
  // R9: unimplemented direct addresses read as zero
  a_r9_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !ctrl_sel && !data_sel) |-> reg_rdata == '0);
  // R7: bank reads never carry upper bits
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && data_sel && fn != FN_ADDR) |-> reg_rdata[DATA_W-1:LED_W] == '0);

endmodule

// File: tb/sim_mmd_indirect_unit.sv
module sim_mmd_indirect_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [9:0]  led_wr_stb;
  logic [79:0] led_words;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mmd_indirect_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .led_wr_stb(led_wr_stb), .led_words(led_words)
  );

  typedef struct packed {
    logic        rd;
    logic [4:0]  a;
    logic [15:0] d;
    logic [3:0]  req;
  } vec_t;

  localparam logic [4:0] C = 5'h0D;
  localparam logic [4:0] D = 5'h0E;
  localparam int NV = 49;

  localparam vec_t VT [NV] = '{
    '{1'b0, C, 16'h001F, 4'd3},
    '{1'b0, D, 16'h01E0, 4'd3},
    '{1'b1, D, 16'h01E0, 4'd3},  // R3 pointer read-back
    '{1'b1, C, 16'h001F, 4'd2},  // R2
    '{1'b0, C, 16'h401F, 4'd4},
    '{1'b1, D, 16'h00C5, 4'd1},  // R1
    '{1'b1, D, 16'h00C5, 4'd4},  // R4 no advance
    '{1'b0, C, 16'h801F, 4'd5},
    '{1'b1, D, 16'h00C5, 4'd5},  // R5 walk, R1 values
    '{1'b1, D, 16'h0067, 4'd5},
    '{1'b1, D, 16'h0070, 4'd5},
    '{1'b1, D, 16'h0003, 4'd5},
    '{1'b1, D, 16'h0020, 4'd5},
    '{1'b1, D, 16'h0000, 4'd5},
    '{1'b1, D, 16'h0040, 4'd5},
    '{1'b1, D, 16'h0000, 4'd5},
    '{1'b1, D, 16'h0040, 4'd5},
    '{1'b1, D, 16'h0020, 4'd5},
    '{1'b1, D, 16'h0000, 4'd8},  // R8 beyond bank
    '{1'b0, C, 16'h0000, 4'd5},
    '{1'b1, D, 16'h01EB, 4'd5},  // R5 pointer advanced past bank
    '{1'b0, C, 16'hFFFF, 4'd2},
    '{1'b1, C, 16'hC01F, 4'd2},  // R2 middle bits dropped
    '{1'b0, C, 16'h001F, 4'd6},
    '{1'b0, D, 16'h01E2, 4'd6},
    '{1'b0, C, 16'hC01F, 4'd6},
    '{1'b1, D, 16'h0070, 4'd6},  // R6 read, no advance
    '{1'b1, D, 16'h0070, 4'd6},
    '{1'b0, D, 16'hABCD, 4'd6},
    '{1'b1, D, 16'h0003, 4'd6},  // R6 write advanced
    '{1'b0, C, 16'h001F, 4'd6},
    '{1'b1, D, 16'h01E3, 4'd6},
    '{1'b0, D, 16'h01E2, 4'd7},
    '{1'b0, C, 16'h401F, 4'd7},
    '{1'b1, D, 16'h00CD, 4'd7},  // R7 low byte only
    '{1'b0, C, 16'h401E, 4'd8},
    '{1'b1, D, 16'h0000, 4'd8},  // R8 foreign device
    '{1'b0, D, 16'h1234, 4'd8},
    '{1'b0, C, 16'h401F, 4'd8},
    '{1'b1, D, 16'h00CD, 4'd8},  // R8 write ignored
    '{1'b1, 5'h00, 16'h0000, 4'd9},  // R9
    '{1'b0, C, 16'h001F, 4'd5},
    '{1'b0, D, 16'h01E8, 4'd5},
    '{1'b0, C, 16'h801F, 4'd5},
    '{1'b0, D, 16'h0011, 4'd5},
    '{1'b0, D, 16'h0022, 4'd5},
    '{1'b0, C, 16'h001F, 4'd5},
    '{1'b1, D, 16'h01EA, 4'd5},  // R5 writes advance
    '{1'b1, 5'h1F, 16'h0000, 4'd9}   // R9
  };

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic rd, input logic [4:0] a, input logic [15:0] d, input int req);
    @(negedge clk);
    reg_addr = a;
    reg_wr = !rd;
    reg_rd = rd;
    reg_wdata = rd ? 16'h0 : d;
    #1;
    if (rd) check($sformatf("R%0d", req), 80'(reg_rdata), 80'(d));
    @(posedge clk);
    #1;
    reg_wr = 1'b0;
    reg_rd = 1'b0;
  endtask

  function automatic logic [79:0] reset_words();
    logic [7:0] v [10] = '{8'hC5, 8'h67, 8'h70, 8'h03, 8'h20,
                          8'h00, 8'h40, 8'h00, 8'h40, 8'h20};
    logic [79:0] r = '0;
    for (int i = 0; i < 10; i++) r[i*8 +: 8] = v[i];
    return r;
  endfunction

  initial begin
    logic [79:0] expw;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset words", led_words, reset_words());
    check("R10 idle strobe", 80'(led_wr_stb), 80'h0);

    for (int k = 0; k < NV; k++) op(VT[k].rd, VT[k].a, VT[k].d, int'(VT[k].req));

    expw = reset_words();
    expw[2*8 +: 8] = 8'hCD;
    expw[8*8 +: 8] = 8'h11;
    expw[9*8 +: 8] = 8'h22;
    @(negedge clk);
    check("R10 word bus after writes", led_words, expw);

    // R10: strobe for word 4 during a data-mode write
    op(1'b0, C, 16'h001F, 10);
    op(1'b0, D, 16'h01E4, 10);
    op(1'b0, C, 16'h401F, 10);
    @(negedge clk);
    reg_addr = D; reg_wr = 1'b1; reg_wdata = 16'h0077;
    #1 check("R10 strobe", 80'(led_wr_stb), 80'h010);
    @(posedge clk); #1 reg_wr = 1'b0;
    @(negedge clk);
    expw[4*8 +: 8] = 8'h77;
    check("R10 stored word", led_words, expw);

    // R8: foreign device write raises no strobe
    op(1'b0, C, 16'h4010, 8);
    @(negedge clk);
    reg_addr = D; reg_wr = 1'b1; reg_wdata = 16'h00EE;
    #1 check("R8 foreign strobe", 80'(led_wr_stb), 80'h0);
    @(posedge clk); #1 reg_wr = 1'b0;
    @(negedge clk);
    check("R8 foreign bus", led_words, expw);

    // R1: a second reset restores the power-on words
    rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 re-reset", led_words, reset_words());
    op(1'b1, C, 16'h0000, 2);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule